// File: doc/BRIEF.md
# Adaptive Replica Admission Controller

This block sits beside a private second-level cache and decides, for each block dropped by the first-level cache, whether a local replica should be kept. Only blocks known to be read by several cores and written by none are candidates. For those, a pseudo-random draw is compared against a probability picked by the current replication level. A higher level keeps more replicas, which means more local hits but less room for unique data.

The level is tuned by a feedback loop. Four pulse inputs report evidence. Two of them estimate what raising the level would gain (hit cycles saved) and what it would cost (extra miss cycles). The other two estimate what lowering it would gain (miss cycles avoided) and what it would cost (hit cycles lost). The counts are weighed once a fixed number of events has arrived. Each such interval predicts up, down or hold, and the level moves one step only after a run of identical predictions.

Top module: `repl_level_ctrl`

## Requirements
- R1: The share type is encoded as 0 = single requestor, 1 = shared read-only, 2 = shared read-write, 3 = reserved. Only type 1 can ever yield a replicate decision.
- R2: Each eviction gives a decision one cycle later: `dec_valid_o` is high for exactly the cycle after `evict_i`, and is low otherwise.
- R3: Levels 0..7 map to replicate probabilities of 0, 1/64, 1/16, 1/8, 1/4, 1/2, 3/4 and 1, in 64ths. Level 0 never replicates, and level 7 replicates every read-only eviction.
- R4: At the levels in between, the share of read-only evictions that are replicated over 2048 draws lies within E/8+24 of E = 2048*p.
- R5: After reset, `level_o` equals INIT_LEVEL (default 4) and both decision outputs are low.
- R6: Each asserted pulse input counts as one event, including pulses in the same cycle. An interval is weighed in the first cycle in which the stored count is at least EVT_LIMIT (256), and the counters then restart with that cycle's pulses.
- R7: An interval predicts up when the up-gain count exceeds the up-cost count. Otherwise it predicts down when the down-gain count exceeds the down-cost count. Otherwise it predicts hold. Up has priority.
- R8: The level moves one step in the predicted direction on the clock edge that records the fourth consecutive identical prediction. From reset, with a single up-gain pulse every cycle, the level is unchanged after 1024 edges and changed after 1025.
- R9: A hold prediction, or a change of direction, restarts the run, so no level change comes from fewer than four identical predictions in a row.
- R10: The level saturates at 0 and at 7 under further down or up evidence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_i | input | 1 | A first-level eviction is presented this cycle |
| share_i | input | 2 | Share type of the evicted block (R1 encoding) |
| up_gain_i | input | 1 | Pulse: hit cycle a higher level would save |
| up_cost_i | input | 1 | Pulse: miss cycle a higher level would add |
| dn_gain_i | input | 1 | Pulse: miss cycle a lower level would avoid |
| dn_cost_i | input | 1 | Pulse: hit cycle a lower level would lose |
| dec_valid_o | output | 1 | Decision for the previous cycle's eviction is valid |
| dec_repl_o | output | 1 | Keep a local replica |
| level_o | output | 3 | Current replication level |

## Verification
The admission filter is swept across all eight levels with long runs of read-only evictions. The two end levels must give exact all-or-nothing results, while the middle levels are checked against their probability bands, which separates a wrong threshold table from a wrong comparison. The other share types are tried at a middle and at the top level to show that only the read-only code is admitted. The level loop is driven four ways, and exact edge counts are used to tell apart an off-by-one interval length, a miscounted streak and a wrong direction priority:
- one pulse per cycle;
- two pulses per cycle;
- mixed up and down evidence;
- a hold interval inserted into an up run.

// File: rtl/repl_pkg.sv
package repl_pkg;
  localparam int LVL_N = 8;
  localparam int LVL_W = 3;
  localparam int RND_W = 16;

  typedef enum logic [1:0] {
    SH_SINGLE = 2'd0,
    SH_RO     = 2'd1,
    SH_RW     = 2'd2,
    SH_RSVD   = 2'd3
  } share_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  // probability of a level in 64ths
  function automatic logic [6:0] level_num64(input logic [LVL_W-1:0] lvl);
    case (lvl)
      3'd0: return 7'd0;
      3'd1: return 7'd1;
      3'd2: return 7'd4;
      3'd3: return 7'd8;
      3'd4: return 7'd16;
      3'd5: return 7'd32;
      3'd6: return 7'd48;
      default: return 7'd64;
    endcase
  endfunction

  // threshold on the RND_W-bit draw, one bit wider so that 1.0 fits
  function automatic logic [RND_W:0] level_thr(input logic [LVL_W-1:0] lvl);
    return (RND_W+1)'(level_num64(lvl)) << (RND_W - 6);
  endfunction

  function automatic dir_e predict(input logic [31:0] up_g, input logic [31:0] up_c,
                                   input logic [31:0] dn_g, input logic [31:0] dn_c);
    if (up_g > up_c) return DIR_UP;
    if (dn_g > dn_c) return DIR_DN;
    return DIR_HOLD;
  endfunction

  function automatic logic [2:0] pop4(input logic [3:0] v);
    return 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
  endfunction

  function automatic logic [LVL_W-1:0] step_level(input logic [LVL_W-1:0] lvl, input dir_e d);
    if (d == DIR_UP && lvl != LVL_W'(LVL_N-1)) return lvl + 1'b1;
    if (d == DIR_DN && lvl != '0) return lvl - 1'b1;
    return lvl;
  endfunction
endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign rnd_o = state_q;

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R3
endmodule

// File: rtl/repl_filter.sv
module repl_filter
  import repl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evict_i,
  input  logic [1:0]       share_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic             dec_valid_o,
  output logic             dec_repl_o
);
  share_e          share_w;
  logic            cand_w;
  logic            draw_hit_w;
  logic [RND_W:0]  thr_w;

  assign share_w    = share_e'(share_i);
  assign cand_w     = (share_w == SH_RO);
  assign thr_w      = level_thr(level_i);
  assign draw_hit_w = ({1'b0, rnd_i} < thr_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_repl_o  <= 1'b0;
    end else begin
      dec_valid_o <= evict_i;
      dec_repl_o  <= evict_i && cand_w && draw_hit_w;
    end
  end

  AST_ONLY_RO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_repl_o |-> $past(evict_i && share_i == 2'd1)); // R1
  AST_DEC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    evict_i |=> dec_valid_o); // R2
  AST_LVL0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evict_i && level_i == '0) |-> !dec_repl_o); // R3
  AST_LVL7_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evict_i && share_i == 2'd1 && level_i == LVL_W'(LVL_N-1)) |-> dec_repl_o); // R3
endmodule

// File: rtl/repl_interval.sv
module repl_interval
  import repl_pkg::*;
#(
  parameter int EVT_LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_gain_i,
  input  logic up_cost_i,
  input  logic dn_gain_i,
  input  logic dn_cost_i,
  output logic eval_o,
  output dir_e dir_o
);
  localparam int CNT_W = $clog2(EVT_LIMIT + 4) + 1;

  logic [3:0]       pulse_w;
  logic [CNT_W-1:0] cnt_q [4];
  logic [CNT_W-1:0] evt_q;
  logic [2:0]       inc_w;

  assign pulse_w = {dn_cost_i, dn_gain_i, up_cost_i, up_gain_i};
  assign inc_w   = pop4(pulse_w);
  assign eval_o  = (evt_q >= CNT_W'(EVT_LIMIT));
  assign dir_o   = predict(32'(cnt_q[0]), 32'(cnt_q[1]), 32'(cnt_q[2]), 32'(cnt_q[3]));

  for (genvar g = 0; g < 4; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (eval_o) cnt_q[g] <= CNT_W'(pulse_w[g]);
      else             cnt_q[g] <= cnt_q[g] + CNT_W'(pulse_w[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (eval_o) evt_q <= CNT_W'(inc_w);
    else             evt_q <= evt_q + CNT_W'(inc_w);
  end

  AST_EVT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    eval_o |=> (evt_q <= CNT_W'(4))); // R6
  AST_EVT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q < CNT_W'(EVT_LIMIT + 4)); // R6
endmodule

// File: rtl/repl_level.sv
module repl_level
  import repl_pkg::*;
#(
  parameter int CONFIRM    = 4,
  parameter int INIT_LEVEL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  dir_e             dir_i,
  output logic [LVL_W-1:0] level_o,
  output logic             confirm_o
);
  localparam int STK_W = $clog2(CONFIRM + 1);

  logic [STK_W-1:0] streak_q;
  logic [STK_W-1:0] streak_nx;
  dir_e             last_q;
  logic [LVL_W-1:0] level_q;

  assign streak_nx = (dir_i == last_q) ? streak_q + 1'b1 : STK_W'(1);
  assign confirm_o = eval_i && (dir_i != DIR_HOLD) && (streak_nx == STK_W'(CONFIRM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
      last_q   <= DIR_HOLD;
      level_q  <= LVL_W'(INIT_LEVEL);
    end else if (eval_i) begin
      last_q <= dir_i;
      if (dir_i == DIR_HOLD) begin
        streak_q <= '0;
      end else if (confirm_o) begin
        streak_q <= '0;
        level_q  <= step_level(level_q, dir_i);
      end else begin
        streak_q <= streak_nx;
      end
    end
  end

  assign level_o = level_q;

  AST_LEVEL_ON_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> $past(confirm_o)); // R8
  AST_STREAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    streak_q < STK_W'(CONFIRM)); // R9
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eval_i && dir_i == DIR_HOLD) |-> (streak_q == '0)); // R9
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(level_q == LVL_W'(LVL_N-1) && dir_i == DIR_UP) |-> (level_q == LVL_W'(LVL_N-1))); // R10
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(level_q == '0 && dir_i == DIR_DN) |-> (level_q == '0)); // R10
endmodule

// File: rtl/repl_level_ctrl.sv
module repl_level_ctrl
  import repl_pkg::*;
#(
  parameter int EVT_LIMIT  = 256,
  parameter int CONFIRM    = 4,
  parameter int INIT_LEVEL = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evict_i,
  input  logic [1:0] share_i,
  input  logic       up_gain_i,
  input  logic       up_cost_i,
  input  logic       dn_gain_i,
  input  logic       dn_cost_i,
  output logic       dec_valid_o,
  output logic       dec_repl_o,
  output logic [2:0] level_o
);
  logic [RND_W-1:0] rnd_w;
  logic             eval_w;
  dir_e             dir_w;
  logic             confirm_w;
  logic [LVL_W-1:0] level_w;

  repl_lfsr #(.W(RND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_o(rnd_w)
  );

  repl_interval #(.EVT_LIMIT(EVT_LIMIT)) u_intv (
    .clk(clk), .rst_n(rst_n),
    .up_gain_i(up_gain_i), .up_cost_i(up_cost_i),
    .dn_gain_i(dn_gain_i), .dn_cost_i(dn_cost_i),
    .eval_o(eval_w), .dir_o(dir_w)
  );

  repl_level #(.CONFIRM(CONFIRM), .INIT_LEVEL(INIT_LEVEL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_w), .dir_i(dir_w),
    .level_o(level_w), .confirm_o(confirm_w)
  );

  repl_filter u_filt (
    .clk(clk), .rst_n(rst_n), .evict_i(evict_i), .share_i(share_i),
    .level_i(level_w), .rnd_i(rnd_w),
    .dec_valid_o(dec_valid_o), .dec_repl_o(dec_repl_o)
  );

  assign level_o = level_w;

  AST_MOVE_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (level_w != $past(level_w)) |->
      ((level_w == $past(level_w) + 1'b1) || (level_w == $past(level_w) - 1'b1))); // R8
  AST_CONFIRM_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_w |-> eval_w); // R6
endmodule

// File: tb/sim_repl_level_ctrl.sv
module sim_repl_level_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evict_i = 1'b0;
  logic [1:0] share_i = 2'd0;
  logic       up_gain_i = 1'b0, up_cost_i = 1'b0, dn_gain_i = 1'b0, dn_cost_i = 1'b0;
  logic       dec_valid_o, dec_repl_o;
  logic [2:0] level_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  repl_level_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evict_i(evict_i), .share_i(share_i),
    .up_gain_i(up_gain_i), .up_cost_i(up_cost_i),
    .dn_gain_i(dn_gain_i), .dn_cost_i(dn_cost_i),
    .dec_valid_o(dec_valid_o), .dec_repl_o(dec_repl_o), .level_o(level_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int num64(input int lvl);
    case (lvl)
      0: return 0;   1: return 1;   2: return 4;   3: return 8;
      4: return 16;  5: return 32;  6: return 48;  default: return 64;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    {evict_i, up_gain_i, up_cost_i, dn_gain_i, dn_cost_i} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive a pulse pattern for n edges; returns at a negedge with inputs cleared
  task automatic drive(input logic [3:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      {dn_cost_i, dn_gain_i, up_cost_i, up_gain_i} = pat;
      @(posedge clk);
      @(negedge clk);
    end
    {dn_cost_i, dn_gain_i, up_cost_i, up_gain_i} = '0;
  endtask

  task automatic measure(input logic [1:0] sh, input int n, output int nrep, output int nval);
    nrep = 0; nval = 0;
    for (int i = 0; i < n; i++) begin
      evict_i = 1'b1; share_i = sh;
      @(posedge clk);
      @(negedge clk);
      if (dec_valid_o) nval++;
      if (dec_repl_o)  nrep++;
    end
    evict_i = 1'b0;
  endtask

  task automatic bump(input logic [3:0] pat, input int exp_lvl);
    int start;
    start = int'(level_o);
    for (int i = 0; i < 3000; i++) begin
      {dn_cost_i, dn_gain_i, up_cost_i, up_gain_i} = pat;
      @(posedge clk);
      @(negedge clk);
      if (int'(level_o) != start) break;
    end
    {dn_cost_i, dn_gain_i, up_cost_i, up_gain_i} = '0;
    check(int'(level_o) == exp_lvl, "R8 level step", int'(level_o), exp_lvl);
  endtask

  task automatic rate_check(input int lvl);
    int nrep, nval, e, tol;
    measure(2'd1, 2048, nrep, nval);
    e = 2048 * num64(lvl) / 64;
    check(nval == 2048, "R2 decision count", nval, 2048);
    if (lvl == 0 || lvl == 7)
      check(nrep == e, "R3 end level rate", nrep, e);
    else begin
      tol = e / 8 + 24;
      check(nrep >= e - tol && nrep <= e + tol, "R4 level rate", nrep, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int nrep, nval;
    @(negedge clk);
    do_reset();
    // R5 reset state
    check(level_o == 3'd4, "R5 reset level", int'(level_o), 4);
    check(!dec_valid_o && !dec_repl_o, "R5 reset decision", int'({dec_valid_o, dec_repl_o}), 0);

    // R1 non read-only types never replicate at level 4
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      measure(2'(s), 256, nrep, nval);
      check(nrep == 0, "R1 non-RO at level 4", nrep, 0);
    end
    // R2 no decision without an eviction
    @(posedge clk); @(negedge clk);
    check(!dec_valid_o, "R2 idle valid low", int'(dec_valid_o), 0);

    // R8 exact timing, one up-gain pulse per cycle
    do_reset();
    drive(4'b0001, 1024);
    check(level_o == 3'd4, "R8 before fourth interval", int'(level_o), 4);
    drive(4'b0001, 1);
    check(level_o == 3'd5, "R8 on fourth interval", int'(level_o), 5);

    // R6 two events per cycle halve the interval (up-gain + down-cost)
    do_reset();
    drive(4'b1001, 512);
    check(level_o == 3'd4, "R6 two pulses, before", int'(level_o), 4);
    drive(4'b1001, 1);
    check(level_o == 3'd5, "R6 two pulses, after", int'(level_o), 5);

    // R7 up has priority over down evidence
    do_reset();
    drive(4'b0101, 513);
    check(level_o == 3'd5, "R7 up priority", int'(level_o), 5);
    // R7 down alone
    do_reset();
    drive(4'b0100, 1025);
    check(level_o == 3'd3, "R7 down prediction", int'(level_o), 3);

    // R9 a hold interval restarts the run
    do_reset();
    drive(4'b0001, 769);
    drive(4'b1010, 128);
    drive(4'b0001, 800);
    check(level_o == 3'd4, "R9 hold restarts run", int'(level_o), 4);
    drive(4'b0001, 300);
    check(level_o == 3'd5, "R9 run completes after hold", int'(level_o), 5);

    // sweep the filter across all levels
    do_reset();
    rate_check(4);
    for (int l = 5; l <= 7; l++) begin
      bump(4'b0001, l);
      rate_check(l);
    end
    measure(2'd2, 256, nrep, nval);
    check(nrep == 0, "R1 RW at level 7", nrep, 0);
    measure(2'd0, 256, nrep, nval);
    check(nrep == 0, "R1 single at level 7", nrep, 0);
    drive(4'b0001, 2100);
    check(level_o == 3'd7, "R10 top saturation", int'(level_o), 7);
    for (int l = 6; l >= 0; l--) begin
      bump(4'b0100, l);
      rate_check(l);
    end
    drive(4'b0100, 2100);
    check(level_o == 3'd0, "R10 bottom saturation", int'(level_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule